// File: doc/BRIEF.md
# Chained Four-Bit-Slice Priority Encoder

This block reduces a wide vector of request lines to the binary position of the highest-numbered line that is set, together with a flag that says whether any line is set. It is purely combinational. It suits arbitration and interrupt selection, where the most significant request must win in the same cycle it appears.

The vector is split into groups of four. Each group is served by an identical slice. A "higher group already found" flag enters at the most significant slice, which has it tied low. Each slice passes the flag to the next less significant slice, with its own requests ORed in. A slice produces a two-bit position within its group only when no group above it has a request. The top level merges the group number of the single winning slice with that slice's local position to form the full index. The width is a parameter. It must be a multiple of four and at least eight.

Top module: `cpe_prio_enc`

## Requirements
- R1: When at least one request line is set, `index_o` equals the bit position of the highest-numbered set line in `req_i`.
- R2: `valid_o` is 1 exactly when at least one bit of `req_i` is 1.
- R3: When no request line is set, `index_o` is all zeros.
- R4: Request lines in lower groups (bit positions below 4*g) have no effect on `index_o` while any line in a more significant group g or above is set.
- R5: Within one group of four (positions 4g+3 down to 4g), position 4g+3 wins over 4g+2, which wins over 4g+1, which wins over 4g. The low two bits of `index_o` give the offset inside the group.
- R6: The outputs follow `req_i` with no clock. A change on the inputs shows at the outputs in the same time step, with no register on the path.
- R7: The same behaviour (R1 to R3) holds for a wider configuration of 32 request lines, which has eight slices and a 5-bit index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | REQ_W | Request lines; a higher bit number means a higher priority |
| valid_o | output | 1 | Some request line is set |
| index_o | output | $clog2(REQ_W) | Position of the winning request, zero when idle |

## Verification
The block has no state. A fault in the flag ripple or in a slice's gating shows at the ports in the same evaluation as the input change that exposes it. A flag that fails to propagate lets a lower slice OR its code into the index, which corrupts the index bits. A flag that is stuck high hides a real winner. The 16-line configuration is driven through every input pattern, so any such fault shows as a wrong index or valid on some pattern. Stuck lower-group codes and group-boundary faults are also probed by directed patterns. The wider configuration is covered by random and sparse vectors.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
  localparam int unsigned SLICE_W = 4;
  localparam int unsigned LOC_W   = 2;
  typedef logic [LOC_W-1:0] loc_t;
endpackage

// File: rtl/cpe_slice.sv
module cpe_slice
  import cpe_pkg::*;
(
  input  logic [SLICE_W-1:0] x_i,
  input  logic               found_i,
  output logic               found_o,
  output logic               hit_o,
  output loc_t               loc_o
);
  logic any_req;

  always_comb begin
    any_req = |x_i;
    found_o = found_i | any_req;
    hit_o   = ~found_i & any_req;
    loc_o[1] = ~found_i & (x_i[3] | x_i[2]);
    loc_o[0] = ~found_i & (x_i[3] | (x_i[1] & ~x_i[2]));
  end
endmodule

// File: rtl/cpe_chain.sv
module cpe_chain
  import cpe_pkg::*;
#(
  parameter int unsigned REQ_W = 16,
  localparam int unsigned N_SLICE = REQ_W / SLICE_W
) (
  input  logic [REQ_W-1:0]   req_i,
  output logic [N_SLICE-1:0] hit_o,
  output loc_t               loc_o [N_SLICE],
  output logic               any_o
);
  // flag[g+1] enters slice g; the top slice sees a constant low flag.
  logic [N_SLICE:0] flag;

  assign flag[N_SLICE] = 1'b0;

  for (genvar g = 0; g < N_SLICE; g++) begin : g_slice
    cpe_slice u_slice (
      .x_i     (req_i[g*SLICE_W +: SLICE_W]),
      .found_i (flag[g+1]),
      .found_o (flag[g]),
      .hit_o   (hit_o[g]),
      .loc_o   (loc_o[g])
    );
  end

  assign any_o = flag[0];
endmodule

// File: rtl/cpe_merge.sv
module cpe_merge
  import cpe_pkg::*;
#(
  parameter int unsigned REQ_W = 16,
  localparam int unsigned N_SLICE = REQ_W / SLICE_W,
  localparam int unsigned IDX_W   = $clog2(REQ_W)
) (
  input  logic [N_SLICE-1:0] hit_i,
  input  loc_t               loc_i [N_SLICE],
  output logic [IDX_W-1:0]   index_o
);
  always_comb begin
    index_o = '0;
    for (int g = 0; g < int'(N_SLICE); g++) begin
      if (hit_i[g]) begin
        index_o = index_o | IDX_W'(g * int'(SLICE_W) + int'(loc_i[g]));
      end
    end
  end
endmodule

// File: rtl/cpe_prio_enc.sv
module cpe_prio_enc
  import cpe_pkg::*;
#(
  parameter int unsigned REQ_W = 16,
  localparam int unsigned N_SLICE = REQ_W / SLICE_W,
  localparam int unsigned IDX_W   = $clog2(REQ_W)
) (
  input  logic [REQ_W-1:0] req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] index_o
);
  logic [N_SLICE-1:0] hit;
  loc_t               loc [N_SLICE];
  logic               any;

  cpe_chain #(.REQ_W(REQ_W)) u_chain (
    .req_i (req_i),
    .hit_o (hit),
    .loc_o (loc),
    .any_o (any)
  );

  cpe_merge #(.REQ_W(REQ_W)) u_merge (
    .hit_i   (hit),
    .loc_i   (loc),
    .index_o (index_o)
  );

  assign valid_o = any;
endmodule

// File: rtl/cpe_prio_enc_chk.sv
module cpe_prio_enc_chk #(
  parameter int unsigned REQ_W = 16,
  localparam int unsigned IDX_W = $clog2(REQ_W)
) (
  input logic [REQ_W-1:0] req_i,
  input logic             valid_o,
  input logic [IDX_W-1:0] index_o
);
  always_comb begin
    // R2
    a_r2_valid_any: assert (valid_o == (req_i != '0));
    // R3
    if (!valid_o) begin
      a_r3_idle_zero: assert (index_o == '0);
    end
    // R1: winner is set and nothing above it is set
    if (valid_o) begin
      a_r1_winner_set: assert (req_i[index_o] == 1'b1);
      a_r1_none_above: assert ((req_i >> index_o) == REQ_W'(1));
    end
  end
endmodule

bind cpe_prio_enc cpe_prio_enc_chk #(.REQ_W(REQ_W)) u_chk (
  .req_i   (req_i),
  .valid_o (valid_o),
  .index_o (index_o)
);

// File: tb/test_cpe_prio_enc.sv
module test_cpe_prio_enc;
  localparam int unsigned W16 = 16;
  localparam int unsigned W32 = 32;
  localparam int unsigned I16 = $clog2(W16);
  localparam int unsigned I32 = $clog2(W32);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W16-1:0] req16 = '0;
  logic           vld16;
  logic [I16-1:0] idx16;
  logic [W32-1:0] req32 = '0;
  logic           vld32;
  logic [I32-1:0] idx32;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  cpe_prio_enc #(.REQ_W(W16)) i_cpe_prio_enc (
    .req_i (req16), .valid_o (vld16), .index_o (idx16));
  cpe_prio_enc #(.REQ_W(W32)) i_cpe_prio_enc_w32 (
    .req_i (req32), .valid_o (vld32), .index_o (idx32));

  function automatic int ref_idx(input logic [63:0] v, input int w);
    for (int b = w - 1; b >= 0; b--) if (v[b]) return b;
    return -1;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic check16(input string rq);
    int r;
    r = ref_idx(64'(req16), W16);
    chk({rq, " valid"}, int'(vld16), (r >= 0) ? 1 : 0);
    chk({rq, " index"}, int'(idx16), (r >= 0) ? r : 0);
  endtask

  task automatic apply16(input logic [W16-1:0] v, input string rq);
    @(posedge clk); req16 = v;
    @(negedge clk); check16(rq);
  endtask

  task automatic t_reset_state;
    apply16('0, "R2 R3 idle");
  endtask

  task automatic t_exhaustive;
    for (int v = 0; v < (1 << W16); v++) apply16(W16'(v), "R1 exhaustive");
  endtask

  task automatic t_single_bits;
    for (int b = 0; b < int'(W16); b++) apply16(W16'(1) << b, "R1 single");
  endtask

  task automatic t_lower_ignored;
    for (int g = 1; g < int'(W16 / 4); g++) begin
      for (int m = 0; m < 16; m++) begin
        logic [W16-1:0] v;
        v = (W16'(1) << (4 * g)) | (W16'($urandom) & ((W16'(1) << (4 * g)) - 1'b1));
        v = v ^ W16'(m);
        v[4 * g] = 1'b1;
        @(posedge clk); req16 = v;
        @(negedge clk);
        chk("R4 lower ignored", int'(idx16), ref_idx(64'(v), W16));
      end
    end
  endtask

  task automatic t_within_group;
    for (int g = 0; g < int'(W16 / 4); g++) begin
      for (int n = 1; n < 16; n++) begin
        logic [W16-1:0] v;
        v = W16'(n) << (4 * g);
        @(posedge clk); req16 = v;
        @(negedge clk);
        chk("R5 in-group offset", int'(idx16[1:0]), ref_idx(64'(n), 4));
      end
    end
  endtask

  task automatic t_comb;
    @(negedge clk);
    req16 = 16'h0100;
    #1;
    chk("R6 no clock index", int'(idx16), 8);
    req16 = 16'h0000;
    #1;
    chk("R6 no clock valid", int'(vld16), 0);
  endtask

  task automatic t_wide;
    for (int k = 0; k < 3000; k++) begin
      logic [W32-1:0] v;
      int r;
      v = W32'($urandom);
      if (k % 3 == 1) v = v & W32'($urandom) & W32'($urandom) & W32'($urandom);
      if (k % 3 == 2) v = W32'(1) << (k % 32);
      if (k == 0) v = '0;
      @(posedge clk); req32 = v;
      @(negedge clk);
      r = ref_idx(64'(v), W32);
      chk("R7 wide valid", int'(vld32), (r >= 0) ? 1 : 0);
      chk("R7 wide index", int'(idx32), (r >= 0) ? r : 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_single_bits();
    t_within_group();
    t_lower_ignored();
    t_comb();
    t_exhaustive();
    t_wide();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule